// File: doc/BRIEF.md
# Interrupt Distributor State Registers

This block keeps the per-interrupt state of an interrupt distributor for a parameterised number of interrupt IDs (96 by default). For every ID it stores an enable bit, a pending bit, an active bit, the recorded line level, a model bit, an edge-trigger bit, a priority byte and a target byte. Software reaches this state through a byte-addressed register bus with 32-bit data and byte strobes. Separate write-one-to-set and write-one-to-clear banks control enables and pendings. Hardware interrupt lines enter at ID 32 and upward.

A downstream arbiter receives the enable, pending, level and trigger vectors and the flattened priority array, and picks a winner from them. The CPU interface sends back two strobes. The acknowledge strobe clears the pending bit and marks the ID active. The completion strobe clears the active bit and raises pending again if the interrupt is a level interrupt, is enabled and still has its line high.

A bus request is sampled on a rising clock edge. Its read data and its error flag appear on the registered outputs during the following cycle. Writes take effect at that same edge.

Top module: `irq_dist_regs`

## Requirements
- R1: After reset the distributor enable is 0, and all pending, active and level bits are 0. All priority and target bytes are 0. IDs 0 to 14 are enabled and edge-triggered, and every other ID is disabled and level-triggered (trigger bit 0).
- R2: Input line k belongs to ID 32+k. When the line rises, the level bit becomes 1 at the same edge, and pending is set if the ID is edge-triggered or enabled. A rising line on a disabled level-triggered ID does not set pending. A falling line clears only the level bit. A line that stays at one value changes nothing.
- R3: Enables are written through two banks: set at 0x100 and clear at 0x180. ID 32w+b is bit b of word w in each bank. A 1 bit sets or clears the enable, and a 0 bit leaves it alone. A read of either bank returns the current enable bits.
- R4: A set-enable write to a level-triggered ID whose recorded level is 1 also sets that ID's pending bit.
- R5: Pendings are written through two banks: set at 0x200 and clear at 0x280, with the same bit layout and write-1 rules as R3. A read of either bank returns the pending bits.
- R6: The priority byte of ID n is at byte 0x400+n, and its target byte is at 0x800+n. Only lanes with their strobe set are written. The priority bytes are exported with ID n at bits 8n+7:8n.
- R7: The configuration word at 0xC00+4w covers IDs 16w to 16w+15. For ID 16w+j, bit 2j is the model bit and bit 2j+1 is the edge-trigger bit. Only strobed lanes are written, and the word reads back as stored.
- R8: Bit 0 of offset 0x000 is the distributor enable, readable and writable, and it drives the enable output. Offset 0x004 reads (number of IDs / 32) - 1, which is 2 by default.
- R9: A write to 0xF00 sets the pending bit of the ID carried in write-data bits 9:0.
- R10: A read at 0xFE0+4n for n = 0 to 7 returns an identification byte in bits 7:0, with the upper bits 0. The bytes, in order of n, are 0x90, 0x13, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1.
- R11: The acknowledge strobe for an ID clears its pending bit and sets its active bit. The active bits read at 0x300, laid out as in R3. The completion strobe clears the active bit, and sets pending again if the ID is level-triggered, enabled and its level is 1.
- R12: Some accesses are errors: an unmapped offset, a word that names IDs at or above the configured count, a write to the active or identification ranges, a read of 0xF00, and a 0xF00 write that carries an out-of-range ID. For any of these, the error output is 1 for exactly one cycle, the read data is 0 and no state changes. Valid accesses return the error output as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_IRQ-32 | Hardware interrupt lines, line k is ID 32+k |
| bus_req | input | 1 | Register access request, one cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_err | output | 1 | Access error, the cycle after the request |
| cpu_ack_vld | input | 1 | Acknowledge strobe |
| cpu_ack_id | input | 10 | ID being acknowledged |
| cpu_done_vld | input | 1 | Completion strobe |
| cpu_done_id | input | 10 | ID being completed |
| dist_en | output | 1 | Distributor enable |
| en_vec | output | NUM_IRQ | Enable bit per ID |
| pend_vec | output | NUM_IRQ | Pending bit per ID |
| lvl_vec | output | NUM_IRQ | Recorded line level per ID |
| trig_vec | output | NUM_IRQ | Edge-trigger bit per ID |
| prio_flat | output | 8*NUM_IRQ | Priority byte per ID |

## Verification
The hardest case is the pair of level-sensitive re-pend paths. Each needs an ID that is level-triggered, with its line already recorded high, and then either a set-enable write or a completion strobe while the line is still up. The stimulus first raises line 0 while ID 32 is disabled and checks that pending stays clear. It then enables ID 32 to trigger R4. Later it raises the line with the ID enabled, acknowledges it, and completes it with the line still high to reach the completion path of R11. Errors are checked by reading back the state that an erroneous write would have changed.

// File: rtl/irq_dist_pkg.sv
// Shared definitions for the interrupt distributor state registers.
// Assumes a 12-bit byte address space with 32-bit data words.
package irq_dist_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ID_W   = 10;

    // Register region selected by the address decoder
    typedef enum logic [3:0] {
        RG_NONE,
        RG_CTRL,
        RG_TYPE,
        RG_SETEN,
        RG_CLREN,
        RG_SETPD,
        RG_CLRPD,
        RG_ACTV,
        RG_PRIO,
        RG_TGT,
        RG_CFG,
        RG_SWTRIG,
        RG_IDENT
    } rgn_e;

    // Identification byte n of the read-only identity window
    function automatic logic [7:0] ident_byte(input logic [2:0] n);
        case (n)
            3'd0:    return 8'h90;
            3'd1:    return 8'h13;
            3'd2:    return 8'h04;
            3'd3:    return 8'h00;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/irq_dist_decode.sv
// Address decoder: maps a bus address to a register region and a word
// index inside it, and flags accesses that are unmapped, out of the ID
// range or in the wrong direction. Purely combinational.
// Assumes NUM_IRQ is a multiple of 32.
module irq_dist_decode
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 96
) (
    input  logic [ADDR_W-1:2] addr,
    input  logic              wr,
    input  logic [ID_W-1:0]   sw_id,
    output rgn_e              rgn,
    output logic [7:0]        idx,
    output logic              bad
);

    localparam int NW32 = NUM_IRQ / 32;
    localparam int NW4  = NUM_IRQ / 4;
    localparam int NW16 = NUM_IRQ / 16;

    // Region and index selection from the upper address bits
    always_comb begin
        rgn = RG_NONE;
        idx = addr[9:2];
        case (addr[11:8])
            4'h0: begin
                if (addr[7:2] == 6'd0)      rgn = RG_CTRL;
                else if (addr[7:2] == 6'd1) rgn = RG_TYPE;
            end
            4'h1: begin
                rgn = addr[7] ? RG_CLREN : RG_SETEN;
                idx = {3'b000, addr[6:2]};
            end
            4'h2: begin
                rgn = addr[7] ? RG_CLRPD : RG_SETPD;
                idx = {3'b000, addr[6:2]};
            end
            4'h3: begin
                if (!addr[7]) rgn = RG_ACTV;
                idx = {3'b000, addr[6:2]};
            end
            4'h4, 4'h5, 4'h6, 4'h7: rgn = RG_PRIO;
            4'h8, 4'h9, 4'hA, 4'hB: rgn = RG_TGT;
            4'hC, 4'hD, 4'hE:       rgn = RG_CFG;
            default: begin
                if (addr[7:2] == 6'd0) begin
                    rgn = RG_SWTRIG;
                end else if (addr[7:5] == 3'b111) begin
                    rgn = RG_IDENT;
                    idx = {5'b00000, addr[4:2]};
                end
            end
        endcase
    end

    // Error classification by region, range and direction
    always_comb begin
        case (rgn)
            RG_NONE:                      bad = 1'b1;
            RG_CTRL, RG_TYPE:             bad = 1'b0;
            RG_SETEN, RG_CLREN,
            RG_SETPD, RG_CLRPD:           bad = int'(idx) >= NW32;
            RG_ACTV:                      bad = wr || (int'(idx) >= NW32);
            RG_PRIO, RG_TGT:              bad = int'(idx) >= NW4;
            RG_CFG:                       bad = int'(idx) >= NW16;
            RG_SWTRIG:                    bad = !wr || (int'(sw_id) >= NUM_IRQ);
            default:                      bad = wr;
        endcase
    end

endmodule

// File: rtl/irq_dist_edge.sv
// Line level tracker: records the last sampled level of each hardware
// interrupt line and reports a one-cycle rise indication.
// Assumes the lines are already synchronous to clk.
module irq_dist_edge #(
    parameter int NUM_EXT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] line_in,
    output logic [NUM_EXT-1:0] lvl_q,
    output logic [NUM_EXT-1:0] rise
);

    // Rise is a new high level against the recorded one
    assign rise = line_in & ~lvl_q;

    // Record the current line levels
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= line_in;
    end

endmodule

// File: rtl/irq_dist_bytes.sv
// Byte-per-ID storage used for priority and target fields; word w of
// the region holds IDs 4w to 4w+3, lane L holding ID 4w+L.
// Assumes NUM_IRQ is a multiple of 4.
module irq_dist_bytes #(
    parameter int NUM_IRQ = 96
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [7:0]           idx,
    input  logic [31:0]          wdata,
    input  logic [3:0]           wstrb,
    output logic [8*NUM_IRQ-1:0] flat
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_byte
        localparam int WORD = i / 4;
        localparam int LANE = i % 4;
        logic [7:0] byte_q;

        // Update this ID's byte when its word and lane are written
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= 8'h00;
            else if (wr && idx == 8'(WORD) && wstrb[LANE])
                byte_q <= wdata[8*LANE +: 8];
        end

        assign flat[8*i +: 8] = byte_q;
    end

endmodule

// File: rtl/irq_dist_state.sv
// Per-ID state bits: enable, pending, active, model and trigger.
// Applies the set/clear banks, the level and edge pending rules, the
// software trigger, and the acknowledge and completion strobes.
// When a set and a clear of pending coincide, the set wins.
// Assumes at most one bus operation per cycle.
module irq_dist_state
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int RST_EN  = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] rise,
    input  logic [NUM_IRQ-1:0] lvl,
    input  logic [31:0]        wdata,
    input  logic [31:0]        wmask,
    input  logic [7:0]         idx,
    input  logic               seten_wr,
    input  logic               clren_wr,
    input  logic               setpd_wr,
    input  logic               clrpd_wr,
    input  logic               cfg_wr,
    input  logic               sw_vld,
    input  logic [ID_W-1:0]    sw_id,
    input  logic               ack_vld,
    input  logic [ID_W-1:0]    ack_id,
    input  logic               done_vld,
    input  logic [ID_W-1:0]    done_id,
    output logic [NUM_IRQ-1:0] en_v,
    output logic [NUM_IRQ-1:0] pend_v,
    output logic [NUM_IRQ-1:0] act_v,
    output logic [NUM_IRQ-1:0] model_v,
    output logic [NUM_IRQ-1:0] trig_v
);

    logic [31:0] wbits;
    assign wbits = wdata & wmask;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
        localparam int W32 = i / 32;
        localparam int B32 = i % 32;
        localparam int W16 = i / 16;
        localparam int B16 = 2 * (i % 16);

        logic en_q, pend_q, act_q, model_q, trig_q;
        logic bank_hit, cfg_hit, sw_hit, ack_hit, done_hit;
        logic pend_set, pend_clr;

        assign bank_hit = (idx == 8'(W32)) && wbits[B32];
        assign cfg_hit  = cfg_wr && (idx == 8'(W16)) && wmask[B16];
        assign sw_hit   = sw_vld && (sw_id == ID_W'(i));
        assign ack_hit  = ack_vld && (ack_id == ID_W'(i));
        assign done_hit = done_vld && (done_id == ID_W'(i));

        // Pending set sources: line rise, level enable, bank, trigger, re-pend
        assign pend_set = (rise[i] && (trig_q || en_q))
                        || (seten_wr && bank_hit && !trig_q && lvl[i])
                        || (setpd_wr && bank_hit)
                        || sw_hit
                        || (done_hit && !trig_q && en_q && lvl[i]);
        assign pend_clr = (clrpd_wr && bank_hit) || ack_hit;

        // Update this ID's state bits
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q    <= (i < RST_EN);
                trig_q  <= (i < RST_EN);
                pend_q  <= 1'b0;
                act_q   <= 1'b0;
                model_q <= 1'b0;
            end else begin
                if (seten_wr && bank_hit)      en_q <= 1'b1;
                else if (clren_wr && bank_hit) en_q <= 1'b0;
                pend_q <= (pend_q && !pend_clr) || pend_set;
                if (ack_hit)       act_q <= 1'b1;
                else if (done_hit) act_q <= 1'b0;
                if (cfg_hit) begin
                    model_q <= wdata[B16];
                    trig_q  <= wdata[B16+1];
                end
            end
        end

        assign en_v[i]    = en_q;
        assign pend_v[i]  = pend_q;
        assign act_v[i]   = act_q;
        assign model_v[i] = model_q;
        assign trig_v[i]  = trig_q;
    end

endmodule

// File: rtl/irq_dist_regs.sv
// Top of the interrupt distributor state registers: decodes bus
// accesses, owns the distributor enable, routes writes to the state,
// priority and target stores, and registers read data and error.
// Assumes NUM_IRQ is a multiple of 32 and above EXT_BASE, and that one
// request arrives per cycle at most.
module irq_dist_regs
    import irq_dist_pkg::*;
#(
    parameter int NUM_IRQ  = 96,
    parameter int EXT_BASE = 32,
    parameter int RST_EN   = 15
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IRQ-EXT_BASE-1:0] irq_in,
    input  logic                      bus_req,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic [3:0]                bus_wstrb,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      bus_err,
    input  logic                      cpu_ack_vld,
    input  logic [ID_W-1:0]           cpu_ack_id,
    input  logic                      cpu_done_vld,
    input  logic [ID_W-1:0]           cpu_done_id,
    output logic                      dist_en,
    output logic [NUM_IRQ-1:0]        en_vec,
    output logic [NUM_IRQ-1:0]        pend_vec,
    output logic [NUM_IRQ-1:0]        lvl_vec,
    output logic [NUM_IRQ-1:0]        trig_vec,
    output logic [8*NUM_IRQ-1:0]      prio_flat
);

    localparam int NUM_EXT = NUM_IRQ - EXT_BASE;
    localparam int NW32    = NUM_IRQ / 32;
    localparam int NW4     = NUM_IRQ / 4;
    localparam int NW16    = NUM_IRQ / 16;

    rgn_e                 rgn;
    logic [7:0]           idx;
    logic                 bad;
    logic                 wr_ok, rd_ok;
    logic [31:0]          wmask;
    logic [31:0]          rd_mux;
    logic [NUM_EXT-1:0]   lvl_ext, rise_ext;
    logic [NUM_IRQ-1:0]   rise_v, act_v, model_v;
    logic [2*NUM_IRQ-1:0] cfg_flat;
    logic [8*NUM_IRQ-1:0] tgt_flat;
    logic                 dist_en_q;
    logic                 unused_addr;

    assign unused_addr = ^bus_addr[1:0];

    irq_dist_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
        .addr  (bus_addr[ADDR_W-1:2]),
        .wr    (bus_wr),
        .sw_id (bus_wdata[ID_W-1:0]),
        .rgn   (rgn),
        .idx   (idx),
        .bad   (bad)
    );

    assign wr_ok = bus_req && bus_wr && !bad;
    assign rd_ok = bus_req && !bus_wr && !bad;
    assign wmask = {{8{bus_wstrb[3]}}, {8{bus_wstrb[2]}},
                    {8{bus_wstrb[1]}}, {8{bus_wstrb[0]}}};

    irq_dist_edge #(.NUM_EXT(NUM_EXT)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (irq_in),
        .lvl_q   (lvl_ext),
        .rise    (rise_ext)
    );

    assign lvl_vec = {lvl_ext, {EXT_BASE{1'b0}}};
    assign rise_v  = {rise_ext, {EXT_BASE{1'b0}}};

    irq_dist_state #(.NUM_IRQ(NUM_IRQ), .RST_EN(RST_EN)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise_v),
        .lvl      (lvl_vec),
        .wdata    (bus_wdata),
        .wmask    (wmask),
        .idx      (idx),
        .seten_wr (wr_ok && rgn == RG_SETEN),
        .clren_wr (wr_ok && rgn == RG_CLREN),
        .setpd_wr (wr_ok && rgn == RG_SETPD),
        .clrpd_wr (wr_ok && rgn == RG_CLRPD),
        .cfg_wr   (wr_ok && rgn == RG_CFG),
        .sw_vld   (wr_ok && rgn == RG_SWTRIG),
        .sw_id    (bus_wdata[ID_W-1:0]),
        .ack_vld  (cpu_ack_vld),
        .ack_id   (cpu_ack_id),
        .done_vld (cpu_done_vld),
        .done_id  (cpu_done_id),
        .en_v     (en_vec),
        .pend_v   (pend_vec),
        .act_v    (act_v),
        .model_v  (model_v),
        .trig_v   (trig_vec)
    );

    irq_dist_bytes #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ok && rgn == RG_PRIO),
        .idx   (idx),
        .wdata (bus_wdata),
        .wstrb (bus_wstrb),
        .flat  (prio_flat)
    );

    irq_dist_bytes #(.NUM_IRQ(NUM_IRQ)) u_tgt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_ok && rgn == RG_TGT),
        .idx   (idx),
        .wdata (bus_wdata),
        .wstrb (bus_wstrb),
        .flat  (tgt_flat)
    );

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cfg
        assign cfg_flat[2*i]   = model_v[i];
        assign cfg_flat[2*i+1] = trig_vec[i];
    end

    // Select the read word for the decoded region
    always_comb begin
        rd_mux = '0;
        case (rgn)
            RG_CTRL: rd_mux = {31'b0, dist_en_q};
            RG_TYPE: rd_mux = 32'(NW32 - 1);
            RG_SETEN, RG_CLREN:
                for (int w = 0; w < NW32; w++)
                    if (idx == 8'(w)) rd_mux = en_vec[32*w +: 32];
            RG_SETPD, RG_CLRPD:
                for (int w = 0; w < NW32; w++)
                    if (idx == 8'(w)) rd_mux = pend_vec[32*w +: 32];
            RG_ACTV:
                for (int w = 0; w < NW32; w++)
                    if (idx == 8'(w)) rd_mux = act_v[32*w +: 32];
            RG_PRIO:
                for (int w = 0; w < NW4; w++)
                    if (idx == 8'(w)) rd_mux = prio_flat[32*w +: 32];
            RG_TGT:
                for (int w = 0; w < NW4; w++)
                    if (idx == 8'(w)) rd_mux = tgt_flat[32*w +: 32];
            RG_CFG:
                for (int w = 0; w < NW16; w++)
                    if (idx == 8'(w)) rd_mux = cfg_flat[32*w +: 32];
            RG_IDENT: rd_mux = {24'b0, ident_byte(idx[2:0])};
            default:  rd_mux = '0;
        endcase
    end

    // Distributor enable register and registered bus response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dist_en_q <= 1'b0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            if (wr_ok && rgn == RG_CTRL && bus_wstrb[0])
                dist_en_q <= bus_wdata[0];
            bus_rdata <= rd_ok ? rd_mux : '0;
            bus_err   <= bus_req && bad;
        end
    end

    assign dist_en = dist_en_q;

endmodule

// File: rtl/irq_dist_regs_chk.sv
// Property checker for irq_dist_regs, attached by bind below.
module irq_dist_regs_chk #(
    parameter int NUM_IRQ  = 96,
    parameter int EXT_BASE = 32,
    parameter int RST_EN   = 15
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_IRQ-EXT_BASE-1:0] irq_in,
    input logic                        bus_req,
    input logic                        bus_err,
    input logic                        cpu_ack_vld,
    input logic                        cpu_done_vld,
    input logic                        dist_en,
    input logic [NUM_IRQ-1:0]          en_vec,
    input logic [NUM_IRQ-1:0]          pend_vec,
    input logic [NUM_IRQ-1:0]          lvl_vec,
    input logic [NUM_IRQ-1:0]          trig_vec,
    input logic [8*NUM_IRQ-1:0]        prio_flat
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!dist_en && pend_vec == '0 && lvl_vec == '0
                          && (&en_vec[RST_EN-1:0]) && (&trig_vec[RST_EN-1:0])));

    // R12
    err_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_req));

    // R12
    err_hold_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (en_vec == $past(en_vec) && trig_vec == $past(trig_vec)));

    // R12
    err_hold_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> prio_flat == $past(prio_flat));

    for (genvar k = 0; k < NUM_IRQ - EXT_BASE; k++) begin : g_line
        // R2
        lvl_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> lvl_vec[EXT_BASE+k] == $past(irq_in[k]));

        // R2
        edge_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_in[k] && !lvl_vec[EXT_BASE+k] && trig_vec[EXT_BASE+k])
            |=> pend_vec[EXT_BASE+k]);

        // R2
        fall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!irq_in[k] && lvl_vec[EXT_BASE+k] && !bus_req
             && !cpu_ack_vld && !cpu_done_vld)
            |=> pend_vec[EXT_BASE+k] == $past(pend_vec[EXT_BASE+k]));
    end

endmodule

bind irq_dist_regs irq_dist_regs_chk #(
    .NUM_IRQ  (NUM_IRQ),
    .EXT_BASE (EXT_BASE),
    .RST_EN   (RST_EN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_in       (irq_in),
    .bus_req      (bus_req),
    .bus_err      (bus_err),
    .cpu_ack_vld  (cpu_ack_vld),
    .cpu_done_vld (cpu_done_vld),
    .dist_en      (dist_en),
    .en_vec       (en_vec),
    .pend_vec     (pend_vec),
    .lvl_vec      (lvl_vec),
    .trig_vec     (trig_vec),
    .prio_flat    (prio_flat)
);

// File: tb/irq_dist_regs_tb.sv
// Directed bench for irq_dist_regs: one task per scenario.
module irq_dist_regs_tb;

    localparam int NUM_IRQ  = 96;
    localparam int EXT_BASE = 32;
    localparam int NUM_EXT  = NUM_IRQ - EXT_BASE;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_EXT-1:0]   irq_in = '0;
    logic                 bus_req = 1'b0;
    logic                 bus_wr = 1'b0;
    logic [11:0]          bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [3:0]           bus_wstrb = '0;
    logic [31:0]          bus_rdata;
    logic                 bus_err;
    logic                 cpu_ack_vld = 1'b0;
    logic [9:0]           cpu_ack_id = '0;
    logic                 cpu_done_vld = 1'b0;
    logic [9:0]           cpu_done_id = '0;
    logic                 dist_en;
    logic [NUM_IRQ-1:0]   en_vec, pend_vec, lvl_vec, trig_vec;
    logic [8*NUM_IRQ-1:0] prio_flat;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    irq_dist_regs u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_in       (irq_in),
        .bus_req      (bus_req),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_wstrb    (bus_wstrb),
        .bus_rdata    (bus_rdata),
        .bus_err      (bus_err),
        .cpu_ack_vld  (cpu_ack_vld),
        .cpu_ack_id   (cpu_ack_id),
        .cpu_done_vld (cpu_done_vld),
        .cpu_done_id  (cpu_done_id),
        .dist_en      (dist_en),
        .en_vec       (en_vec),
        .pend_vec     (pend_vec),
        .lvl_vec      (lvl_vec),
        .trig_vec     (trig_vec),
        .prio_flat    (prio_flat)
    );

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                             input logic [3:0] s, output logic e);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0; bus_wstrb = '0;
        e = bus_err;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        e = bus_err;
    endtask

    task automatic wr_ok(input string req, input logic [11:0] a,
                         input logic [31:0] d, input logic [3:0] s);
        logic e;
        bus_write(a, d, s, e);
        chk_eq({req, " write err"}, 32'(e), 32'd0);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic e;
        bus_read(a, d, e);
        chk_eq({req, " read err"}, 32'(e), 32'd0);
        chk_eq(req, d, exp);
    endtask

    task automatic set_line(input int k, input logic v);
        @(negedge clk);
        irq_in[k] = v;
        @(negedge clk);
    endtask

    task automatic pulse_ack(input logic [9:0] id);
        @(negedge clk);
        cpu_ack_vld = 1'b1; cpu_ack_id = id;
        @(negedge clk);
        cpu_ack_vld = 1'b0;
    endtask

    task automatic pulse_done(input logic [9:0] id);
        @(negedge clk);
        cpu_done_vld = 1'b1; cpu_done_id = id;
        @(negedge clk);
        cpu_done_vld = 1'b0;
    endtask

    // R1: reset state at ports and through the register map
    task automatic t_reset;
        chk_eq("R1 dist_en", 32'(dist_en), 32'd0);
        chk_eq("R1 pend low", pend_vec[31:0], 32'd0);
        chk_eq("R1 lvl ext", lvl_vec[63:32], 32'd0);
        rd_chk("R1 enable word0", 12'h100, 32'h0000_7FFF);
        rd_chk("R1 enable word1", 12'h104, 32'h0);
        rd_chk("R1 pend word2", 12'h208, 32'h0);
        rd_chk("R1 cfg word0", 12'hC00, 32'h2AAA_AAAA);
        rd_chk("R1 prio", 12'h45C, 32'h0);
        rd_chk("R1 ctrl", 12'h000, 32'h0);
    endtask

    // R8: distributor enable and the ID count word
    task automatic t_ctrl;
        wr_ok("R8", 12'h000, 32'h1, 4'hF);
        rd_chk("R8 ctrl", 12'h000, 32'h1);
        chk_eq("R8 dist_en", 32'(dist_en), 32'd1);
        rd_chk("R8 type", 12'h004, 32'd2);
    endtask

    // R2, R4, R5, R7: line rules, level enable, pending banks
    task automatic t_lines;
        set_line(0, 1'b1);
        chk_eq("R2 level recorded", 32'(lvl_vec[32]), 32'd1);
        chk_eq("R2 disabled level no pend", 32'(pend_vec[32]), 32'd0);
        wr_ok("R4", 12'h104, 32'h1, 4'h1);
        rd_chk("R4 enable pends", 12'h204, 32'h1);
        rd_chk("R3 enable set", 12'h104, 32'h1);
        wr_ok("R5", 12'h284, 32'h1, 4'h1);
        rd_chk("R5 clear pend", 12'h204, 32'h0);
        set_line(0, 1'b0);
        chk_eq("R2 level cleared", 32'(lvl_vec[32]), 32'd0);
        wr_ok("R7", 12'hC08, 32'h8, 4'h1);
        rd_chk("R7 cfg id33", 12'hC08, 32'h8);
        set_line(1, 1'b1);
        chk_eq("R2 edge disabled pends", 32'(pend_vec[33]), 32'd1);
        wr_ok("R5", 12'h284, 32'h2, 4'h1);
        repeat (5) @(negedge clk);
        chk_eq("R2 steady high no pend", 32'(pend_vec[33]), 32'd0);
        wr_ok("R5", 12'h204, 32'h2, 4'h1);
        rd_chk("R5 set pend", 12'h204, 32'h2);
        set_line(1, 1'b0);
        chk_eq("R2 fall keeps pend", 32'(pend_vec[33]), 32'd1);
        chk_eq("R2 fall clears level", 32'(lvl_vec[33]), 32'd0);
        wr_ok("R5", 12'h284, 32'h2, 4'h1);
        set_line(0, 1'b1);
        chk_eq("R2 enabled level pends", 32'(pend_vec[32]), 32'd1);
    endtask

    // R11, R9: acknowledge, completion re-pend, software trigger
    task automatic t_ack;
        pulse_ack(10'd32);
        chk_eq("R11 ack clears pend", 32'(pend_vec[32]), 32'd0);
        rd_chk("R11 active set", 12'h304, 32'h1);
        pulse_done(10'd32);
        chk_eq("R11 done re-pends", 32'(pend_vec[32]), 32'd1);
        rd_chk("R11 active cleared", 12'h304, 32'h0);
        set_line(0, 1'b0);
        wr_ok("R5", 12'h284, 32'h1, 4'h1);
        wr_ok("R9", 12'hF00, 32'd40, 4'h3);
        rd_chk("R9 sw trigger", 12'h204, 32'h100);
        pulse_ack(10'd40);
        rd_chk("R11 active id40", 12'h304, 32'h100);
        pulse_done(10'd40);
        chk_eq("R11 no re-pend line low", 32'(pend_vec[40]), 32'd0);
        rd_chk("R11 active id40 clear", 12'h304, 32'h0);
    endtask

    // R3, R5, R6, R7: banks, byte fields and configuration edges
    task automatic t_fields;
        wr_ok("R3", 12'h180, 32'h8, 4'h1);
        rd_chk("R3 clear enable", 12'h100, 32'h0000_7FF7);
        rd_chk("R3 clear bank read", 12'h180, 32'h0000_7FF7);
        wr_ok("R5", 12'h208, 32'h8000_0000, 4'h8);
        chk_eq("R5 id95 pend", 32'(pend_vec[95]), 32'd1);
        wr_ok("R5", 12'h288, 32'h8000_0000, 4'h8);
        chk_eq("R5 id95 clear", 32'(pend_vec[95]), 32'd0);
        wr_ok("R6", 12'h45C, 32'hAABB_CCDD, 4'h5);
        rd_chk("R6 prio lanes", 12'h45C, 32'h00BB_00DD);
        chk_eq("R6 prio export", 32'(prio_flat[94*8 +: 8]), 32'hBB);
        wr_ok("R6", 12'h800, 32'h1122_3344, 4'hF);
        rd_chk("R6 target", 12'h800, 32'h1122_3344);
        wr_ok("R7", 12'hC14, 32'hC000_0000, 4'h8);
        rd_chk("R7 cfg id95", 12'hC14, 32'hC000_0000);
        chk_eq("R7 trig export", 32'(trig_vec[95]), 32'd1);
    endtask

    // R10: identification window
    task automatic t_ident;
        rd_chk("R10 byte0", 12'hFE0, 32'h90);
        rd_chk("R10 byte1", 12'hFE4, 32'h13);
        rd_chk("R10 byte5", 12'hFF4, 32'hF0);
        rd_chk("R10 byte7", 12'hFFC, 32'hB1);
    endtask

    // R12: errors flag once and leave state alone
    task automatic t_errors;
        logic [31:0] d;
        logic e;
        logic [NUM_IRQ-1:0] pend_before;
        bus_read(12'h10C, d, e);
        chk_eq("R12 bank range err", 32'(e), 32'd1);
        chk_eq("R12 err rdata", d, 32'd0);
        @(negedge clk);
        chk_eq("R12 err one cycle", 32'(bus_err), 32'd0);
        bus_write(12'h460, 32'hFFFF_FFFF, 4'hF, e);
        chk_eq("R12 prio range err", 32'(e), 32'd1);
        rd_chk("R12 prio unchanged", 12'h45C, 32'h00BB_00DD);
        bus_write(12'h300, 32'h1, 4'hF, e);
        chk_eq("R12 active write err", 32'(e), 32'd1);
        rd_chk("R12 active unchanged", 12'h300, 32'h0);
        bus_read(12'hF00, d, e);
        chk_eq("R12 trigger read err", 32'(e), 32'd1);
        pend_before = pend_vec;
        bus_write(12'hF00, 32'd100, 4'h3, e);
        chk_eq("R12 trigger id err", 32'(e), 32'd1);
        chk_eq("R12 pend unchanged", 32'(pend_vec == pend_before), 32'd1);
        bus_read(12'h008, d, e);
        chk_eq("R12 unmapped err", 32'(e), 32'd1);
        bus_write(12'hC18, 32'hFFFF_FFFF, 4'hF, e);
        chk_eq("R12 cfg range err", 32'(e), 32'd1);
        rd_chk("R12 cfg unchanged", 12'hC14, 32'hC000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_lines();
        t_ack();
        t_fields();
        t_ident();
        t_errors();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule